// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block sits beside a processor that announces each bus cycle only through a 3-bit status code, and it rebuilds the control strobes that memory and I/O need. When the code leaves its passive value, the block starts a cycle. In the first state it pulses an address latch enable for the external address latches and sets the direction of the data buffers. From the second state onward it drives the command strobe that the code selects, plus the data buffer enable. The cycle ends on the clock edge that samples the passive code again.

Two enables gate the strobes. One gates every command, and the other gates only the memory commands. A bus-mode input picks between a system-bus arrangement, in which a shared output acts as the cascade select of an interrupt controller, and an I/O-bus arrangement, in which that output enables the I/O transceivers. Writes come as an early ("advanced") strobe followed by the normal strobe a parameterised number of clocks later. The interface is plain control pins. There is no data stream, so no valid/ready handshake or back-pressure applies.

Top module: `bus_cmd_gen`

## Requirements
- R1: While rst_n is low and in the first clock after it, every command output (all `*_n`) is high, ale, den and shared_en are low, and dir_tx is low.
- R2: A status other than 3'b111 sampled while idle starts a cycle: ale is high for exactly the one clock after that edge. A status of 3'b111 while idle starts nothing.
- R3: Status codes map as follows: 000 interrupt acknowledge (inta_n), 001 I/O read (io_rd_n), 010 I/O write (io_awr_n, io_wr_n), 011 halt, 100 code fetch (mem_rd_n), 101 memory read (mem_rd_n), 110 memory write (mem_awr_n, mem_wr_n), 111 passive. Commands are active low and assert from the second clock of the cycle.
- R4: Commands, den and shared_en deassert in the clock after the edge that samples status 3'b111.
- R5: The advanced write strobe asserts in the second clock of a write cycle. The normal write asserts WR_DELAY clocks later (default 1) and never without the advanced one.
- R6: With cmd_en low, no command output is asserted.
- R7: With mem_en low, mem_rd_n, mem_wr_n and mem_awr_n stay high, while I/O and interrupt acknowledge commands are unaffected.
- R8: dir_tx is 1 for write cycles (010, 110) and 0 for every other started cycle. It is set in the first clock of the cycle and changes only while den is low.
- R9: den is high during the command clocks of every started cycle except halt. In I/O-bus mode (io_bus=1) it stays low for I/O read and write cycles.
- R10: shared_en with io_bus=0 is high during the first and the command clocks of interrupt acknowledge cycles. With io_bus=1 it is high during the command clocks of I/O read and write cycles.
- R11: A halt cycle pulses ale but asserts no command and no den.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat | input | 3 | Bus status code from the processor |
| cmd_en | input | 1 | Enables all command outputs |
| mem_en | input | 1 | Enables memory command outputs |
| io_bus | input | 1 | 0 system-bus mode, 1 I/O-bus mode |
| ale | output | 1 | Address latch enable pulse |
| den | output | 1 | Data buffer enable |
| dir_tx | output | 1 | Data buffer direction, 1 transmit |
| mem_rd_n | output | 1 | Memory read command |
| mem_wr_n | output | 1 | Memory write command |
| mem_awr_n | output | 1 | Advanced memory write command |
| io_rd_n | output | 1 | I/O read command |
| io_wr_n | output | 1 | I/O write command |
| io_awr_n | output | 1 | Advanced I/O write command |
| inta_n | output | 1 | Interrupt acknowledge command |
| shared_en | output | 1 | Cascade select or I/O transceiver enable, by io_bus |

## Verification
On every cycle, the assertions check the following. The address strobe lasts a single clock. No command appears without cmd_en, and no memory command appears without mem_en. A normal write never appears without its advanced strobe. At most one kind of command is active. The buffer direction moves only while the buffers are disabled. Only the bench's sweep can show the actual mapping from each status code to its strobe, the position of each strobe inside a cycle, and the return to idle on the passive code. The same holds for the mode-dependent meaning of the shared output. The sweep covers every code under every combination of the enable and mode inputs and compares all outputs in every phase.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [2:0] {
    ST_INTA  = 3'b000,
    ST_IORD  = 3'b001,
    ST_IOWR  = 3'b010,
    ST_HALT  = 3'b011,
    ST_FETCH = 3'b100,
    ST_MRD   = 3'b101,
    ST_MWR   = 3'b110,
    ST_PASS  = 3'b111
  } bus_stat_e;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_CMD} phase_e;

  function automatic logic is_write(bus_stat_e s);
    return (s == ST_IOWR) || (s == ST_MWR);
  endfunction

  function automatic logic is_io(bus_stat_e s);
    return (s == ST_IORD) || (s == ST_IOWR);
  endfunction

  function automatic logic is_mem_rd(bus_stat_e s);
    return (s == ST_FETCH) || (s == ST_MRD);
  endfunction

  function automatic logic has_cmd(bus_stat_e s);
    return (s != ST_HALT) && (s != ST_PASS);
  endfunction
endpackage

// File: rtl/bcg_seq.sv
module bcg_seq
  import bcg_pkg::*;
#(
  parameter int WR_DELAY = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic [2:0] stat_i,
  output phase_e    phase_o,
  output bus_stat_e code_o,
  output logic      late_o,
  output logic      ale_o,
  output logic      dir_tx_o
);
  localparam int CW = $clog2(WR_DELAY + 1);
  localparam logic [CW-1:0] LIM = CW'(WR_DELAY);

  bus_stat_e st;
  phase_e    phase_q;
  bus_stat_e code_q;
  logic [CW-1:0] wcnt_q;
  logic      dtx_q;

  assign st = bus_stat_e'(stat_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      code_q  <= ST_PASS;
      wcnt_q  <= '0;
      dtx_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (st != ST_PASS) begin
          phase_q <= PH_ADDR;
          code_q  <= st;
          wcnt_q  <= '0;
          dtx_q   <= is_write(st);
        end
        PH_ADDR: phase_q <= (st == ST_PASS) ? PH_IDLE : PH_CMD;
        PH_CMD: begin
          if (st == ST_PASS) phase_q <= PH_IDLE;
          else if (wcnt_q != LIM) wcnt_q <= wcnt_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o  = phase_q;
  assign code_o   = code_q;
  assign late_o   = (phase_q == PH_CMD) && (wcnt_q == LIM);
  assign ale_o    = (phase_q == PH_ADDR);
  assign dir_tx_o = dtx_q;

  a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !ale_o);
  a_r4_passive_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CMD && st == ST_PASS) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/bcg_cmd.sv
module bcg_cmd
  import bcg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  phase_e    phase_i,
  input  bus_stat_e code_i,
  input  logic      late_i,
  input  logic      cmd_en_i,
  input  logic      mem_en_i,
  input  logic      io_bus_i,
  output logic      den_o,
  output logic      shared_en_o,
  output logic      mem_rd_n_o,
  output logic      mem_wr_n_o,
  output logic      mem_awr_n_o,
  output logic      io_rd_n_o,
  output logic      io_wr_n_o,
  output logic      io_awr_n_o,
  output logic      inta_n_o
);
  logic act, go, mgo;

  always_comb begin
    act = (phase_i == PH_CMD);
    go  = act && cmd_en_i;
    mgo = go && mem_en_i;
    mem_rd_n_o  = !(mgo && is_mem_rd(code_i));
    mem_awr_n_o = !(mgo && code_i == ST_MWR);
    mem_wr_n_o  = !(mgo && code_i == ST_MWR && late_i);
    io_rd_n_o   = !(go && code_i == ST_IORD);
    io_awr_n_o  = !(go && code_i == ST_IOWR);
    io_wr_n_o   = !(go && code_i == ST_IOWR && late_i);
    inta_n_o    = !(go && code_i == ST_INTA);
    den_o       = act && has_cmd(code_i) && !(io_bus_i && is_io(code_i));
    if (io_bus_i) shared_en_o = act && is_io(code_i);
    else          shared_en_o = (act || phase_i == PH_ADDR) && (code_i == ST_INTA);
  end

  a_r6_ctl_gates_all: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_en_i |-> (&{mem_rd_n_o, mem_wr_n_o, mem_awr_n_o, io_rd_n_o,
                     io_wr_n_o, io_awr_n_o, inta_n_o}));
  a_r7_mem_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en_i |-> (mem_rd_n_o && mem_wr_n_o && mem_awr_n_o));
  a_r5_wr_after_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_n_o |-> !mem_awr_n_o) and (!io_wr_n_o |-> !io_awr_n_o));
  a_r3_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!mem_rd_n_o, !mem_awr_n_o, !io_rd_n_o, !io_awr_n_o, !inta_n_o}));
endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
  import bcg_pkg::*;
#(
  parameter int WR_DELAY = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] stat,
  input  logic       cmd_en,
  input  logic       mem_en,
  input  logic       io_bus,
  output logic       ale,
  output logic       den,
  output logic       dir_tx,
  output logic       mem_rd_n,
  output logic       mem_wr_n,
  output logic       mem_awr_n,
  output logic       io_rd_n,
  output logic       io_wr_n,
  output logic       io_awr_n,
  output logic       inta_n,
  output logic       shared_en
);
  phase_e    phase;
  bus_stat_e code;
  logic      late;

  bcg_seq #(.WR_DELAY(WR_DELAY)) seq_i (
    .clk(clk), .rst_n(rst_n), .stat_i(stat),
    .phase_o(phase), .code_o(code), .late_o(late),
    .ale_o(ale), .dir_tx_o(dir_tx)
  );

  bcg_cmd cmd_i (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .code_i(code), .late_i(late),
    .cmd_en_i(cmd_en), .mem_en_i(mem_en), .io_bus_i(io_bus),
    .den_o(den), .shared_en_o(shared_en),
    .mem_rd_n_o(mem_rd_n), .mem_wr_n_o(mem_wr_n), .mem_awr_n_o(mem_awr_n),
    .io_rd_n_o(io_rd_n), .io_wr_n_o(io_wr_n), .io_awr_n_o(io_awr_n),
    .inta_n_o(inta_n)
  );

  a_r8_dir_only_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_tx) |-> (!den && !$past(den)));
  a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (code == ST_HALT) |-> (!den && inta_n && mem_rd_n && io_rd_n));
endmodule

// File: tb/bus_cmd_gen_tb_top.sv
module bus_cmd_gen_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n = 1'b0;
  logic [2:0] stat = 3'b111;
  logic cmd_en = 1'b0, mem_en = 1'b0, io_bus = 1'b0;
  logic ale, den, dir_tx, mem_rd_n, mem_wr_n, mem_awr_n;
  logic io_rd_n, io_wr_n, io_awr_n, inta_n, shared_en;

  int total = 0, bad = 0;
  bit done = 0;
  bit exp_dtx = 0;

  bus_cmd_gen dut_i (
    .clk(clk), .rst_n(rst_n), .stat(stat), .cmd_en(cmd_en), .mem_en(mem_en),
    .io_bus(io_bus), .ale(ale), .den(den), .dir_tx(dir_tx),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_awr_n(mem_awr_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_awr_n(io_awr_n),
    .inta_n(inta_n), .shared_en(shared_en)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ph: 0 idle after passive, 1 first clock, 2 first command clock, 3 later command clock
  task automatic check_phase(int c, int ph, bit ce, bit ae, bit iob);
    bit cyc, t1, act, late, go, mgo, iocyc;
    int ecmd, acmd;
    string creq;
    cyc   = (c != 7) && (ph != 0);
    t1    = cyc && ph == 1;
    act   = cyc && ph >= 2;
    late  = act && ph == 3;
    go    = act && ce;
    mgo   = go && ae;
    iocyc = (c == 1) || (c == 2);
    ecmd  = {mgo && (c == 4 || c == 5), mgo && c == 6 && late, mgo && c == 6,
             go && c == 1, go && c == 2 && late, go && c == 2, go && c == 0};
    acmd  = 7'(~{mem_rd_n, mem_wr_n, mem_awr_n, io_rd_n, io_wr_n, io_awr_n, inta_n});
    creq  = (c == 3) ? "R11" : !ce ? "R6" : !ae ? "R7" : ph == 3 ? "R5" : ph == 0 ? "R4" : "R3";
    chk("R2", $sformatf("ale code=%0d ph=%0d", c, ph), ale, t1);
    chk(creq, $sformatf("cmds code=%0d ph=%0d ce=%0d ae=%0d", c, ph, ce, ae), acmd, ecmd);
    chk("R9", $sformatf("den code=%0d ph=%0d iob=%0d", c, ph, iob), den,
        act && c != 3 && !(iob && iocyc));
    chk("R10", $sformatf("shared code=%0d ph=%0d iob=%0d", c, ph, iob), shared_en,
        iob ? (act && iocyc) : ((t1 || act) && c == 0));
    chk("R8", $sformatf("dir code=%0d ph=%0d", c, ph), dir_tx, exp_dtx);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "cmds in reset", {mem_rd_n, mem_wr_n, mem_awr_n, io_rd_n, io_wr_n, io_awr_n, inta_n}, 7'h7f);
    chk("R1", "ale/den/shared/dir in reset", {ale, den, shared_en, dir_tx}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cmds after reset", {mem_rd_n, mem_wr_n, mem_awr_n, io_rd_n, io_wr_n, io_awr_n, inta_n}, 7'h7f);
    chk("R1", "ale/den after reset", {ale, den, shared_en, dir_tx}, 0);
    // exhaustive sweep: every code under every enable/mode combination
    for (int m = 0; m < 8; m++) begin
      for (int c = 0; c < 8; c++) begin
        cmd_en = m[0]; mem_en = m[1]; io_bus = m[2];
        stat = 3'(c);
        if (c != 7) exp_dtx = (c == 2) || (c == 6);
        for (int ph = 1; ph <= 3; ph++) begin
          @(negedge clk);
          check_phase(c, ph, m[0], m[1], m[2]);
        end
        stat = 3'b111;
        @(negedge clk);
        check_phase(c, 0, m[0], m[1], m[2]);
        @(negedge clk);
        check_phase(c, 0, m[0], m[1], m[2]);
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule